// File: doc/BRIEF.md
# Speculative Read-Set Conflict Detector

This unit sits beside a processing node's cache and keeps, for each tracked cache line, two flags belonging to the transaction now running on that node. One flag says the transaction loaded from the line, and the other says it stored to it. Stores stay in the node's own buffer until commit, so only the load flag can expose the node to another node's work. Every commit broadcast from another node carries line numbers. When one of those numbers lands on a line that the local transaction loaded, the other node has committed first. The local transaction is then stale, and the unit raises a sticky violation so that the core can restart it.

When it raises a violation, the unit also latches the line that caused it, along with a bit telling whether the local transaction had also stored to that line. The core can use both as feedback. The core drives three strobes: begin a transaction, commit it, or abort it. Each accepted strobe clears all the flags at once. No coherence invalidation takes place here: a matching snoop never updates a line, it only condemns the local transaction.

Top module: `spec_conflict_detector`

## Requirements
- R1: After reset, `violation`, `violLine` and `violWritten` are all 0 and no transaction is open.
- R2: While a transaction is open, a load to line L followed in a later cycle by a snooped commit of L makes `violation` 1 on the clock edge that samples the snoop. `violLine` then reads L.
- R3: A snoop of a line that the open transaction has only stored to, never loaded, leaves `violation` at 0.
- R4: A snoop of a line the open transaction has not touched leaves `violation` at 0.
- R5: Once `violation` is 1, it stays 1 until `txAbort` or `txBegin` is sampled. Loads, stores, snoops and `txCommit` have no effect on any output while it is 1. `txAbort` returns the unit to idle, and `txBegin` opens a fresh transaction.
- R6: Commit, abort and begin each clear all load and store flags. A line loaded before one of them does not cause a violation when it is snooped afterwards.
- R7: With no transaction open, loads, stores and snoops are ignored.
- R8: A snoop is checked only against loads sampled in earlier cycles. A load and a snoop of the same line in the same cycle give no violation, but a later snoop of that line does.
- R9: `txCommit` sampled in the same cycle as a snoop that would hit wins. No violation is raised.
- R10: `violWritten` is 1 when the violating line had also been stored to by the local transaction before the snoop, and 0 otherwise.
- R11: `violLine` and `violWritten` keep the values of the most recent violation until the next violation replaces them. Every line number from 0 to the highest line can be tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txBegin | input | 1 | Open a new transaction (restart when violated) |
| txCommit | input | 1 | Local transaction commits |
| txAbort | input | 1 | Local transaction aborts |
| ldValid | input | 1 | Local speculative load this cycle |
| ldLine | input | LINE_W | Line number of the load |
| stValid | input | 1 | Local speculative store this cycle |
| stLine | input | LINE_W | Line number of the store |
| snpValid | input | 1 | Commit address snooped from another node |
| snpLine | input | LINE_W | Snooped line number |
| violation | output | 1 | Sticky conflict flag |
| violLine | output | LINE_W | Line that caused the latest violation |
| violWritten | output | 1 | That line had also been stored to locally |

## Verification
The assertions assume that at most one of `txBegin`, `txCommit` and `txAbort` is high in a cycle, except for the deliberate commit-with-hit case. They also assume that `snpLine` is meaningful only while `snpValid` is high. The stimulus uses single control strobes, and it makes snoop collisions only in the scenarios written to test priority. A behavioural model built on sets of line numbers predicts all three outputs every cycle. Directed checks at the end of each scenario name the requirement they cover.

// File: rtl/scd_pkg.sv
package scd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_VIOL   = 2'd2
  } scdState_e;

  typedef struct packed {
    logic trackEn;   // record local loads and stores
    logic clearAll;  // flash-clear all flags
    logic capture;   // latch snooped line as offender
  } scdStrobe_t;

endpackage

// File: rtl/scd_datapath.sv
module scd_datapath
  import scd_pkg::*;
#(
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  scdStrobe_t        strobe,
  input  logic              ldValid,
  input  logic [LINE_W-1:0] ldLine,
  input  logic              stValid,
  input  logic [LINE_W-1:0] stLine,
  input  logic              snpValid,
  input  logic [LINE_W-1:0] snpLine,
  output logic              snpHit,
  output logic [LINE_W-1:0] violLine,
  output logic              violWritten
);

  localparam int NUM_LINES = 1 << LINE_W;

  logic [NUM_LINES-1:0] readBits;
  logic [NUM_LINES-1:0] modBits;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic ldHere;
    logic stHere;
    assign ldHere = strobe.trackEn && ldValid && (ldLine == LINE_W'(g));
    assign stHere = strobe.trackEn && stValid && (stLine == LINE_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearAll) begin
        readBits[g] <= 1'b0;
        modBits[g]  <= 1'b0;
      end else begin
        if (ldHere) readBits[g] <= 1'b1;
        if (stHere) modBits[g]  <= 1'b1;
      end
    end
  end

  assign snpHit = snpValid && readBits[snpLine];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violLine    <= '0;
      violWritten <= 1'b0;
    end else if (strobe.capture) begin
      violLine    <= snpLine;
      violWritten <= modBits[snpLine];
    end
  end

endmodule

// File: rtl/scd_ctrl.sv
module scd_ctrl
  import scd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txBegin,
  input  logic       txCommit,
  input  logic       txAbort,
  input  logic       snpHit,
  output scdStrobe_t strobe,
  output logic       violation
);

  scdState_e state, stateNxt;
  logic hitEvent;

  assign hitEvent = (state == ST_ACTIVE) && snpHit && !txCommit && !txAbort;

  always_comb begin
    stateNxt        = state;
    strobe          = '0;
    strobe.trackEn  = (state == ST_ACTIVE);
    strobe.capture  = hitEvent;
    unique case (state)
      ST_IDLE: begin
        if (txBegin) begin
          stateNxt        = ST_ACTIVE;
          strobe.clearAll = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (txCommit || txAbort) begin
          stateNxt        = ST_IDLE;
          strobe.clearAll = 1'b1;
        end else if (hitEvent) begin
          stateNxt = ST_VIOL;
        end else if (txBegin) begin
          strobe.clearAll = 1'b1;
        end
      end
      ST_VIOL: begin
        if (txAbort) begin
          stateNxt        = ST_IDLE;
          strobe.clearAll = 1'b1;
        end else if (txBegin) begin
          stateNxt        = ST_ACTIVE;
          strobe.clearAll = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign violation = (state == ST_VIOL);

endmodule

// File: rtl/spec_conflict_detector.sv
module spec_conflict_detector
  import scd_pkg::*;
#(
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBegin,
  input  logic              txCommit,
  input  logic              txAbort,
  input  logic              ldValid,
  input  logic [LINE_W-1:0] ldLine,
  input  logic              stValid,
  input  logic [LINE_W-1:0] stLine,
  input  logic              snpValid,
  input  logic [LINE_W-1:0] snpLine,
  output logic              violation,
  output logic [LINE_W-1:0] violLine,
  output logic              violWritten
);

  scdStrobe_t strobe;
  logic       snpHit;

  scd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txBegin   (txBegin),
    .txCommit  (txCommit),
    .txAbort   (txAbort),
    .snpHit    (snpHit),
    .strobe    (strobe),
    .violation (violation)
  );

  scd_datapath #(.LINE_W(LINE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .ldValid     (ldValid),
    .ldLine      (ldLine),
    .stValid     (stValid),
    .stLine      (stLine),
    .snpValid    (snpValid),
    .snpLine     (snpLine),
    .snpHit      (snpHit),
    .violLine    (violLine),
    .violWritten (violWritten)
  );

endmodule

// File: rtl/scd_checker.sv
module scd_checker #(
  parameter int LINE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              txBegin,
  input logic              txCommit,
  input logic              txAbort,
  input logic              snpValid,
  input logic [LINE_W-1:0] snpLine,
  input logic              violation,
  input logic [LINE_W-1:0] violLine,
  input logic              violWritten
);

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    violation && !txAbort && !txBegin |=> violation); // R5

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    violation && txAbort |=> !violation); // R5

  AST_RISE_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violation) |-> $past(snpValid)); // R2

  AST_RISE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violation) |-> violLine == $past(snpLine)); // R11

  AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    txCommit && !violation |=> !violation); // R9

  AST_FEEDBACK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> $stable(violLine) && $stable(violWritten)); // R11

endmodule

bind spec_conflict_detector scd_checker #(.LINE_W(LINE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .txBegin     (txBegin),
  .txCommit    (txCommit),
  .txAbort     (txAbort),
  .snpValid    (snpValid),
  .snpLine     (snpLine),
  .violation   (violation),
  .violLine    (violLine),
  .violWritten (violWritten)
);

// File: tb/sim_spec_conflict_detector.sv
module sim_spec_conflict_detector;
  localparam int LINE_W = 6;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txBegin = 0, txCommit = 0, txAbort = 0;
  logic ldValid = 0, stValid = 0, snpValid = 0;
  logic [LINE_W-1:0] ldLine = '0, stLine = '0, snpLine = '0;
  logic violation, violWritten;
  logic [LINE_W-1:0] violLine;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curReq = "R1";

  // model: 0 idle, 1 active, 2 violated
  int mState = 0;
  int rdSet[int];
  int wrSet[int];
  int mLine = 0;
  int mWr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_conflict_detector #(.LINE_W(LINE_W)) u0 (
    .clk(clk), .rstN(rstN), .txBegin(txBegin), .txCommit(txCommit),
    .txAbort(txAbort), .ldValid(ldValid), .ldLine(ldLine),
    .stValid(stValid), .stLine(stLine), .snpValid(snpValid),
    .snpLine(snpLine), .violation(violation), .violLine(violLine),
    .violWritten(violWritten)
  );

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    rdSet.delete();
    wrSet.delete();
  endtask

  task automatic modelStep();
    int sl;
    sl = int'(snpLine);
    if (mState == 1) begin
      if (txCommit || txAbort) begin
        mState = 0; modelClear();
      end else if (snpValid && rdSet.exists(sl)) begin
        mState = 2; mLine = sl; mWr = wrSet.exists(sl) ? 1 : 0;
      end else if (txBegin) begin
        modelClear();
      end else begin
        if (ldValid) rdSet[int'(ldLine)] = 1;
        if (stValid) wrSet[int'(stLine)] = 1;
      end
    end else if (mState == 2) begin
      if (txAbort) begin mState = 0; modelClear(); end
      else if (txBegin) begin mState = 1; modelClear(); end
    end else begin
      if (txBegin) begin mState = 1; modelClear(); end
    end
  endtask

  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    chk(curReq, int'(violation), (mState == 2) ? 1 : 0, "violation");
    chk(curReq, int'(violLine), mLine, "violLine");
    chk(curReq, int'(violWritten), mWr, "violWritten");
    txBegin = 0; txCommit = 0; txAbort = 0;
    ldValid = 0; stValid = 0; snpValid = 0;
  endtask

  task automatic load(int l);  ldValid = 1; ldLine = LINE_W'(l); endtask
  task automatic store(int l); stValid = 1; stLine = LINE_W'(l); endtask
  task automatic snoop(int l); snpValid = 1; snpLine = LINE_W'(l); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1", int'(violation), 0, "violation after reset");
    chk("R1", int'(violLine), 0, "violLine after reset");
    chk("R1", int'(violWritten), 0, "violWritten after reset");

    // R7 idle ignores loads and snoops
    curReq = "R7";
    load(5); step();
    snoop(5); step();
    chk("R7", int'(violation), 0, "idle snoop");

    // R2 basic conflict
    curReq = "R2";
    txBegin = 1; step();
    load(3); step();
    snoop(3); step();
    chk("R2", int'(violation), 1, "violation on read hit");
    chk("R2", int'(violLine), 3, "offending line");
    chk("R10", int'(violWritten), 0, "not written");

    // R5 sticky, commit and further traffic ignored
    curReq = "R5";
    snoop(9); load(9); step();
    txCommit = 1; step();
    step();
    chk("R5", int'(violation), 1, "sticky");
    chk("R5", int'(violLine), 3, "line held");
    txAbort = 1; step();
    chk("R5", int'(violation), 0, "abort clears");

    // R3 store-only, R4 untouched
    curReq = "R3";
    txBegin = 1; step();
    store(7); step();
    snoop(7); step();
    chk("R3", int'(violation), 0, "store-only snoop");
    curReq = "R4";
    snoop(12); step();
    chk("R4", int'(violation), 0, "untouched snoop");

    // R10 read and written line
    curReq = "R10";
    load(7); step();
    snoop(7); step();
    chk("R10", int'(violation), 1, "violation");
    chk("R10", int'(violWritten), 1, "written flag");

    // R6 restart clears flags
    curReq = "R6";
    txBegin = 1; step();
    chk("R6", int'(violation), 0, "begin restarts");
    snoop(7); step();
    chk("R6", int'(violation), 0, "flags cleared by restart");
    load(20); step();
    txCommit = 1; step();
    txBegin = 1; step();
    snoop(20); step();
    chk("R6", int'(violation), 0, "flags cleared by commit");

    // R8 same-cycle load and snoop
    curReq = "R8";
    load(30); snoop(30); step();
    chk("R8", int'(violation), 0, "same cycle no hit");
    snoop(30); step();
    chk("R8", int'(violation), 1, "later snoop hits");
    txAbort = 1; step();

    // R9 commit wins
    curReq = "R9";
    txBegin = 1; step();
    load(40); step();
    snoop(40); txCommit = 1; step();
    chk("R9", int'(violation), 0, "commit beats snoop");
    step();
    chk("R9", int'(violation), 0, "still clear");

    // R11 latest offender held, boundary line
    curReq = "R11";
    txBegin = 1; step();
    load(1); step();
    load(2); step();
    snoop(2); step();
    snoop(1); step();
    chk("R11", int'(violLine), 2, "first offender kept");
    txBegin = 1; step();
    chk("R11", int'(violLine), 2, "held after restart");
    load((1 << LINE_W) - 1); step();
    snoop((1 << LINE_W) - 1); step();
    chk("R11", int'(violLine), (1 << LINE_W) - 1, "top line");
    chk("R11", int'(violation), 1, "top line violation");
    txAbort = 1; step();
    step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule